// File: doc/BRIEF.md
# Legacy Video Range Transaction Router

This block looks at one host transaction at a time and decides where it goes. It checks the address and the transaction type. The result is one of four codes: send it to the downstream hub port, send it to the graphics port, send it to system DRAM, or report that the access is not a legacy video hit, so the normal system decode takes over. The legacy memory windows are the graphics A window (0x000A_0000 to 0x000A_FFFF), the monochrome window (0x000B_0000 to 0x000B_7FFF) and the graphics B window (0x000B_8000 to 0x000B_FFFF). Six monochrome adapter I/O ports are also decoded.

Four configuration inputs steer the result:
- a graphics enable, which moves the three windows to the graphics port;
- a monochrome forward, which sends the monochrome window and its I/O ports back to the hub whatever the graphics enable says;
- an SMM space enable;
- an SMM open bit.

When SMM space is enabled and either SMM is open or the request is a code fetch made in SMM mode, memory accesses in the windows are reclaimed to DRAM. In that case the graphics enable and the monochrome forward have no effect.

A request is taken with a valid/ready handshake. The routing result is registered and shown one clock later with its own valid. It stays held while the consumer stalls. The configuration inputs are sampled on the cycle the request is taken.

Top module: `legacy_route_top`

## Requirements
- R1: A memory request (io flag 0) is tagged by window on `rsp_hit`: 1 for 0x000A0000..0x000AFFFF, 2 for 0x000B0000..0x000B7FFF, 3 for 0x000B8000..0x000BFFFF. All address bits above bit 19 must be zero for a hit.
- R2: With no SMM override, graphics enable 0 and monochrome forward 0, a memory request in any window gets `rsp_dest` = 2'b00 (hub).
- R3: With no SMM override and graphics enable 1, a request in window 1 or window 3 gets `rsp_dest` = 2'b01 (graphics). A request in window 2 also gets 2'b01 when monochrome forward is 0.
- R4: With no SMM override and monochrome forward 1, a request in window 2 gets 2'b00 (hub) whatever the graphics enable is.
- R5: An I/O request (io flag 1) to port 0x3B4, 0x3B5, 0x3B8, 0x3B9, 0x3BA or 0x3BF gets `rsp_dest` 2'b00 and `rsp_hit` 4 when monochrome forward is 1. The full address must equal the port number. Any other I/O request, and any I/O request while monochrome forward is 0, gets 2'b11 with `rsp_hit` 0.
- R6: A memory request in any window gets `rsp_dest` 2'b10 (DRAM) when SMM enable is 1 and either SMM open is 1 or both the code flag and the SMM-mode flag are 1. This holds regardless of graphics enable and monochrome forward. An SMM-mode data access with SMM open 0 is not reclaimed.
- R7: The SMM override never changes the result of an I/O request.
- R8: A memory request outside the three windows gets `rsp_dest` 2'b11 and `rsp_hit` 0.
- R9: `req_ready` equals `!rsp_valid || rsp_ready`. A request taken at a clock edge sets `rsp_valid` with its result after that edge.
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, the result is held. Configuration changes after acceptance never alter it.
- R11: After reset `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | 32 | Transaction address |
| req_is_io | input | 1 | 1 = I/O space, 0 = memory |
| req_code | input | 1 | Request is an instruction fetch |
| req_smm | input | 1 | Request issued in SMM mode |
| cfg_gfx_en | input | 1 | Route legacy windows to graphics port |
| cfg_mono_fwd | input | 1 | Keep monochrome window and ports on hub |
| cfg_smm_en | input | 1 | SMM space enable |
| cfg_smm_open | input | 1 | SMM space open for all accesses |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes result |
| rsp_dest | output | 2 | 00 hub, 01 graphics, 10 DRAM, 11 no legacy hit |
| rsp_hit | output | 3 | 0 none, 1 graphics A, 2 mono, 3 graphics B, 4 mono I/O |

## Verification
The hardest case to reach is a configuration change that lands between acceptance and consumption. That result must stay frozen, and a request waiting behind it must pick up the new settings. The bench stalls the consumer and flips every configuration bit while a competing request waits. It then releases the stall and checks both the held result and the next result. A full sweep over all sixteen configuration patterns and all flag combinations, run at every window edge and every port neighbour, covers the SMM code-versus-data distinction.

// File: rtl/lvr_pkg.sv
package lvr_pkg;
  typedef enum logic [1:0] {
    DST_HUB  = 2'b00,
    DST_GFX  = 2'b01,
    DST_DRAM = 2'b10,
    DST_NONE = 2'b11
  } dest_e;

  typedef enum logic [2:0] {
    HIT_NONE    = 3'd0,
    HIT_GFX_A   = 3'd1,
    HIT_MONO    = 3'd2,
    HIT_GFX_B   = 3'd3,
    HIT_MONO_IO = 3'd4
  } hit_e;

  localparam int NUM_WIN   = 3;
  localparam int NUM_PORTS = 6;

  // window base and log2 size, index order matches hit tag order minus one
  function automatic logic [31:0] win_base(input int idx);
    case (idx)
      0:       return 32'h000A_0000;
      1:       return 32'h000B_0000;
      default: return 32'h000B_8000;
    endcase
  endfunction

  function automatic int win_lg(input int idx);
    return (idx == 0) ? 16 : 15;
  endfunction

  function automatic logic [15:0] mono_port(input int idx);
    case (idx)
      0:       return 16'h03B4;
      1:       return 16'h03B5;
      2:       return 16'h03B8;
      3:       return 16'h03B9;
      4:       return 16'h03BA;
      default: return 16'h03BF;
    endcase
  endfunction

  // SMM reclaim condition, kept separate so a checker can restate it
  function automatic logic smm_reclaim(input logic en, input logic open,
                                       input logic code, input logic smm);
    return en && (open || (code && smm));
  endfunction
endpackage

// File: rtl/lvr_window_decode.sv
module lvr_window_decode
  import lvr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_io,
  output hit_e              mem_hit,
  output logic              io_port_hit
);
  logic [NUM_WIN-1:0]   win_match;
  logic [NUM_PORTS-1:0] port_match;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam int LG = win_lg(w);
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(win_base(w));
    assign win_match[w] = !is_io && ((addr >> LG) == (BASE >> LG));
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam logic [ADDR_W-1:0] PORT = ADDR_W'(mono_port(p));
    assign port_match[p] = is_io && (addr == PORT);
  end

  always_comb begin
    mem_hit = HIT_NONE;
    if (win_match[0])      mem_hit = HIT_GFX_A;
    else if (win_match[1]) mem_hit = HIT_MONO;
    else if (win_match[2]) mem_hit = HIT_GFX_B;
  end

  assign io_port_hit = |port_match;
endmodule

// File: rtl/lvr_policy.sv
module lvr_policy
  import lvr_pkg::*;
(
  input  hit_e  mem_hit,
  input  logic  io_port_hit,
  input  logic  is_io,
  input  logic  code,
  input  logic  smm,
  input  logic  gfx_en,
  input  logic  mono_fwd,
  input  logic  smm_en,
  input  logic  smm_open,
  output dest_e dest,
  output hit_e  hit,
  output logic  smm_override
);
  logic in_window;
  assign in_window    = (mem_hit != HIT_NONE);
  assign smm_override = in_window && smm_reclaim(smm_en, smm_open, code, smm);

  always_comb begin
    dest = DST_NONE;
    hit  = HIT_NONE;
    if (is_io) begin
      if (mono_fwd && io_port_hit) begin
        dest = DST_HUB;
        hit  = HIT_MONO_IO;
      end
    end else if (in_window) begin
      hit = mem_hit;
      if (smm_override)                          dest = DST_DRAM;
      else if (mono_fwd && mem_hit == HIT_MONO)  dest = DST_HUB;
      else if (gfx_en)                           dest = DST_GFX;
      else                                       dest = DST_HUB;
    end
  end
endmodule

// File: rtl/lvr_resp_reg.sv
module lvr_resp_reg
  import lvr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  logic  drain,
  input  dest_e dest_in,
  input  hit_e  hit_in,
  output logic  valid,
  output dest_e dest_q,
  output hit_e  hit_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      dest_q <= DST_NONE;
      hit_q  <= HIT_NONE;
    end else if (load) begin
      valid  <= 1'b1;
      dest_q <= dest_in;
      hit_q  <= hit_in;
    end else if (drain) begin
      valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/legacy_route_top.sv
module legacy_route_top
  import lvr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_is_io,
  input  logic              req_code,
  input  logic              req_smm,
  input  logic              cfg_gfx_en,
  input  logic              cfg_mono_fwd,
  input  logic              cfg_smm_en,
  input  logic              cfg_smm_open,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_dest,
  output logic [2:0]        rsp_hit
);
  hit_e  mem_hit_w;
  logic  io_port_hit_w;
  dest_e dest_w;
  hit_e  hit_w;
  logic  smm_override_w;
  logic  accept_w;
  dest_e dest_q;
  hit_e  hit_q;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept_w  = req_valid && req_ready;

  lvr_window_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr        (req_addr),
    .is_io       (req_is_io),
    .mem_hit     (mem_hit_w),
    .io_port_hit (io_port_hit_w)
  );

  lvr_policy u_pol (
    .mem_hit      (mem_hit_w),
    .io_port_hit  (io_port_hit_w),
    .is_io        (req_is_io),
    .code         (req_code),
    .smm          (req_smm),
    .gfx_en       (cfg_gfx_en),
    .mono_fwd     (cfg_mono_fwd),
    .smm_en       (cfg_smm_en),
    .smm_open     (cfg_smm_open),
    .dest         (dest_w),
    .hit          (hit_w),
    .smm_override (smm_override_w)
  );

  lvr_resp_reg u_rsp (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept_w),
    .drain   (rsp_ready),
    .dest_in (dest_w),
    .hit_in  (hit_w),
    .valid   (rsp_valid),
    .dest_q  (dest_q),
    .hit_q   (hit_q)
  );

  assign rsp_dest = dest_q;
  assign rsp_hit  = hit_q;
endmodule

// File: rtl/lvr_checker.sv
module lvr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       req_is_io,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [1:0] rsp_dest,
  input logic [2:0] rsp_hit,
  input logic       smm_override_w
);
  AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);                                       // R9
  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> req_ready);                                                     // R9
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_dest) && $stable(rsp_hit))); // R10
  AST_RECLAIM_DRAM: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && smm_override_w) |=> (rsp_dest == 2'b10));           // R6
  AST_RECLAIM_NO_IO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_is_io) |=> (rsp_dest != 2'b10));                // R7
  AST_DRAM_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_dest == 2'b10) |-> (rsp_hit >= 3'd1 && rsp_hit <= 3'd3));    // R6
  AST_NONE_NO_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_dest == 2'b11) |-> (rsp_hit == 3'd0));                       // R8
  AST_MONO_IO_HUB: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit == 3'd4) |-> (rsp_dest == 2'b00));                       // R5
endmodule

bind legacy_route_top lvr_checker u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .req_is_io      (req_is_io),
  .rsp_valid      (rsp_valid),
  .rsp_ready      (rsp_ready),
  .rsp_dest       (rsp_dest),
  .rsp_hit        (rsp_hit),
  .smm_override_w (smm_override_w)
);

// File: tb/legacy_route_top_test.sv
module legacy_route_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_is_io = 1'b0;
  logic        req_code = 1'b0;
  logic        req_smm = 1'b0;
  logic        cfg_gfx_en = 1'b0;
  logic        cfg_mono_fwd = 1'b0;
  logic        cfg_smm_en = 1'b0;
  logic        cfg_smm_open = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [1:0]  rsp_dest;
  logic [2:0]  rsp_hit;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  legacy_route_top uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_is_io(req_is_io), .req_code(req_code), .req_smm(req_smm),
    .cfg_gfx_en(cfg_gfx_en), .cfg_mono_fwd(cfg_mono_fwd), .cfg_smm_en(cfg_smm_en),
    .cfg_smm_open(cfg_smm_open), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_dest(rsp_dest), .rsp_hit(rsp_hit)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model: region by numeric range, result as {dest,hit}
  function automatic logic [4:0] model(input logic [31:0] a, input bit io, input bit code,
                                       input bit smm, input logic [3:0] cfg);
    bit gfx = cfg[0], mono = cfg[1], sen = cfg[2], sop = cfg[3];
    int tag = 0;
    if (io) begin
      if (mono && (a == 32'h3B4 || a == 32'h3B5 || a == 32'h3B8 || a == 32'h3B9 ||
                   a == 32'h3BA || a == 32'h3BF)) return {2'b00, 3'd4};
      return {2'b11, 3'd0};
    end
    if (a >= 32'hA0000 && a < 32'hB0000)      tag = 1;
    else if (a >= 32'hB0000 && a < 32'hB8000) tag = 2;
    else if (a >= 32'hB8000 && a < 32'hC0000) tag = 3;
    if (tag == 0) return {2'b11, 3'd0};
    if (sen && (sop || (smm && code))) return {2'b10, 3'(tag)};
    if (tag == 2 && mono) return {2'b00, 3'(tag)};
    return {(gfx ? 2'b01 : 2'b00), 3'(tag)};
  endfunction

  function automatic string tag_of(input logic [31:0] a, input bit io, input bit code,
                                   input bit smm, input logic [3:0] cfg);
    logic [4:0] e = model(a, io, code, smm, cfg);
    if (io) return (cfg[2] ? "R5 R7" : "R5");
    if (e[4:3] == 2'b11) return "R8";
    if (e[4:3] == 2'b10) return "R1 R6";
    if (e[2:0] == 3'd2 && cfg[1]) return "R1 R4";
    if (cfg[0]) return "R1 R3";
    return (cfg[2] ? "R1 R6" : "R1 R2");
  endfunction

  task automatic issue(input logic [31:0] a, input bit io, input bit code, input bit smm,
                       input logic [3:0] cfg);
    req_valid = 1'b1; req_addr = a; req_is_io = io; req_code = code; req_smm = smm;
    cfg_gfx_en = cfg[0]; cfg_mono_fwd = cfg[1]; cfg_smm_en = cfg[2]; cfg_smm_open = cfg[3];
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] addrs[14];
    logic [4:0]  held;
    addrs = '{32'h0009FFFF, 32'h000A0000, 32'h000AFFFF, 32'h000B0000, 32'h000B7FFF,
              32'h000B8000, 32'h000BFFFF, 32'h000C0000, 32'h001A0000, 32'h000003B4,
              32'h000003BF, 32'h000003B6, 32'h000003BB, 32'h000103B5};
    repeat (3) @(negedge clk);
    check("R11 rsp_valid", {31'b0, rsp_valid}, 32'd0);
    check("R11 req_ready", {31'b0, req_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // full sweep, consumer always ready
    for (int i = 0; i < 14; i++)
      for (int f = 0; f < 8; f++)
        for (int c = 0; c < 16; c++) begin
          issue(addrs[i], f[0], f[1], f[2], 4'(c));
          @(negedge clk);
          check({"R9 valid ", tag_of(addrs[i], f[0], f[1], f[2], 4'(c))},
                {31'b0, rsp_valid}, 32'd1);
          check(tag_of(addrs[i], f[0], f[1], f[2], 4'(c)),
                {27'b0, rsp_dest, rsp_hit}, {27'b0, model(addrs[i], f[0], f[1], f[2], 4'(c))});
        end
    req_valid = 1'b0;
    @(negedge clk);
    check("R9 drained", {31'b0, rsp_valid}, 32'd0);

    // backpressure with configuration change after acceptance
    rsp_ready = 1'b0;
    issue(32'h000B1000, 1'b0, 1'b0, 1'b0, 4'b0001);
    @(negedge clk);
    held = model(32'h000B1000, 1'b0, 1'b0, 1'b0, 4'b0001);
    check("R10 first", {27'b0, rsp_dest, rsp_hit}, {27'b0, held});
    issue(32'h000B1000, 1'b0, 1'b0, 1'b0, 4'b1110);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R9 stalled ready", {31'b0, req_ready}, 32'd0);
      check("R10 held", {26'b0, rsp_valid, rsp_dest, rsp_hit}, {26'b0, 1'b1, held});
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 next uses new cfg", {27'b0, rsp_dest, rsp_hit},
          {27'b0, model(32'h000B1000, 1'b0, 1'b0, 1'b0, 4'b1110)});
    @(negedge clk);
    check("R9 empty", {31'b0, rsp_valid}, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule